// File: doc/BRIEF.md
# Chained-Descriptor Memory Copy Channel

This block is one memory-to-memory copy channel. Software loads a source address, a destination address, a next-descriptor pointer and a control word, then issues a start command. The channel moves items one at a time: it reads one item from the source, then writes the same value to the destination. After each item it steps each address by the item width, or keeps it fixed, according to the control word.

When a packet's item count is used up, the channel looks at the next-descriptor pointer. If the pointer is zero, the chain is over: the channel switches itself off and raises a done pulse. Otherwise it fetches a four-word descriptor from memory and loads the four registers from it in one step. It then runs the new packet. A single request port carries data beats and descriptor reads, one transaction at a time.

The control word layout is used both in the software register and in word 3 of a descriptor:

| Bits | Meaning |
|------|---------|
| 11:0 | item count |
| 19:18 | width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| 26 | step the source address |
| 27 | step the destination address |

A descriptor is four words at the pointer address, at offsets +0, +4, +8 and +12:

| Offset | Contents |
|--------|----------|
| +0 | source address |
| +4 | destination address |
| +8 | next pointer |
| +12 | control word |

Top module: `lldma_channel`

## Requirements
- R1: After reset the channel is inactive and all address outputs read zero. While the channel is inactive, a configuration write loads the selected register: select 0 is the source, 1 the destination, 2 the next pointer, 3 the control word. Select 4 with data bit 0 set starts the channel. Selects 5 to 7 have no effect.
- R2: Each item is one read at the source address. It is followed by one write of the value read to the destination address. Items are moved strictly in this order.
- R3: Between consecutive items of a packet, each address steps by the width (1, 2 or 4 bytes) when its step bit is set, and by zero when the bit is clear. After the channel stops, the source and destination outputs show the addresses of the last item moved.
- R4: The next pointer always has its two low bits zero, whether it was loaded by software or from a descriptor.
- R5: When a packet ends and the next pointer is non-zero, the channel reads the four descriptor words at offsets +0, +4, +8 and +12 from the pointer, in that order. It then loads the source, destination, next pointer and control word from them.
- R6: The channel refuses to run a packet in three cases: the width code is 3, the source is not aligned to the width, or the destination is not aligned to the width. In that case it raises a one-cycle err pulse, issues no data traffic and goes inactive. This applies to the software start and to every fetched descriptor.
- R7: A zero next pointer at the end of a packet makes the channel inactive. It raises done for exactly one cycle, and done is never high while the channel is active.
- R8: Configuration writes made while the channel is active change nothing. This includes writes to the next pointer.
- R9: A packet with an item count of zero issues no data beats and goes straight to its end-of-packet step.
- R10: The visible address and pointer registers do not change while descriptor words 0 to 2 arrive. They change together on the cycle the fourth word is accepted.
- R11: A memory request is raised only while the channel is active. Once raised, its address and direction are held until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we | input | 1 | configuration write strobe |
| cfg_sel | input | 3 | register select (0 src, 1 dst, 2 next, 3 control, 4 start) |
| cfg_wdata | input | 32 | configuration write data |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address of the request |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | request accepted; read data valid with it |
| mem_rdata | input | 32 | read data |
| active | output | 1 | channel enabled |
| done | output | 1 | one-cycle pulse at chain end |
| err | output | 1 | one-cycle pulse on a refused packet |
| src_addr | output | 32 | current source address |
| dst_addr | output | 32 | current destination address |
| next_ptr | output | 32 | current next-descriptor pointer |

## Verification
The bench builds the channel with the package defaults: 32-bit addresses and a 12-bit item count. These are enough to run packets of zero to six items at every width, and chains of up to four descriptors that include a zero-count packet. The memory acknowledges each request after 0 to 2 wait cycles. This makes descriptor words arrive spread out in time, which exposes any partial register update. It also gives a configuration write room to land in the middle of a packet.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int ADDR_W   = 32;
  localparam int CNT_W    = 12;
  localparam int CNT_LSB  = 0;
  localparam int WID_LSB  = 18;
  localparam int SINC_BIT = 26;
  localparam int DINC_BIT = 27;
  localparam int DESC_WORDS = 4;
  localparam int WORD_SHIFT = 2;

  localparam logic [2:0] SEL_SRC = 3'd0;
  localparam logic [2:0] SEL_DST = 3'd1;
  localparam logic [2:0] SEL_NXT = 3'd2;
  localparam logic [2:0] SEL_CTL = 3'd3;
  localparam logic [2:0] SEL_GO  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_END, ST_FETCH
  } state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] nxt;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        wcode;
    logic              sinc;
    logic              dinc;
  } desc_t;

  function automatic logic width_ok(input logic [1:0] c);
    return c != 2'd3;
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] c);
    case (c)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] item_step(input logic [1:0] c, input logic inc);
    return inc ? ADDR_W'(width_bytes(c)) : '0;
  endfunction

  function automatic logic is_aligned(input logic [1:0] lo, input logic [1:0] c);
    case (c)
      2'd0:    return 1'b1;
      2'd1:    return ~lo[0];
      default: return lo == 2'b00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
  endfunction

  function automatic desc_t make_desc(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                                      input logic [ADDR_W-1:0] n, input logic [ADDR_W-1:0] c);
    desc_t r;
    r.src   = s;
    r.dst   = d;
    r.nxt   = align_word(n);
    r.cnt   = c[CNT_LSB +: CNT_W];
    r.wcode = c[WID_LSB +: 2];
    r.sinc  = c[SINC_BIT];
    r.dinc  = c[DINC_BIT];
    return r;
  endfunction

endpackage

// File: rtl/lldma_desc_fetch.sv
module lldma_desc_fetch
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic              loaded,
  output desc_t             desc
);

  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] w_q [DESC_WORDS-1];
  logic              beat;

  assign beat   = req && mem_ack;
  assign loaded = beat && (idx == LAST_IDX);
  assign addr   = base_q + (ADDR_W'(idx) << WORD_SHIFT);
  assign desc   = make_desc(w_q[0], w_q[1], w_q[2], mem_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      idx    <= '0;
      base_q <= '0;
    end else if (start) begin
      req    <= 1'b1;
      idx    <= '0;
      base_q <= base;
    end else if (beat) begin
      if (idx == LAST_IDX) req <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DESC_WORDS - 1; k++) w_q[k] <= '0;
    end else if (beat) begin
      for (int k = 0; k < DESC_WORDS - 1; k++)
        if (idx == IDX_W'(k)) w_q[k] <= mem_rdata;
    end
  end

endmodule

// File: rtl/lldma_addr_regs.sv
module lldma_addr_regs
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_sel,
  input  logic [ADDR_W-1:0] sw_data,
  input  logic              load,
  input  desc_t             load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] nxt,
  output logic [CNT_W-1:0]  cnt,
  output logic              bad_cfg
);

  desc_t cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (step) begin
      cur.src <= cur.src + item_step(cur.wcode, cur.sinc);
      cur.dst <= cur.dst + item_step(cur.wcode, cur.dinc);
    end else if (sw_we) begin
      case (sw_sel)
        SEL_SRC: cur.src <= sw_data;
        SEL_DST: cur.dst <= sw_data;
        SEL_NXT: cur.nxt <= align_word(sw_data);
        SEL_CTL: begin
          cur.cnt   <= sw_data[CNT_LSB +: CNT_W];
          cur.wcode <= sw_data[WID_LSB +: 2];
          cur.sinc  <= sw_data[SINC_BIT];
          cur.dinc  <= sw_data[DINC_BIT];
        end
        default: ;
      endcase
    end
  end

  assign src = cur.src;
  assign dst = cur.dst;
  assign nxt = cur.nxt;
  assign cnt = cur.cnt;
  assign bad_cfg = !width_ok(cur.wcode)
                || !is_aligned(cur.src[1:0], cur.wcode)
                || !is_aligned(cur.dst[1:0], cur.wcode);

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              active,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [ADDR_W-1:0] next_ptr
);

  state_e            st;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt;
  logic              bad_cfg;

  // named events
  logic  sw_we, start_cmd, step_ev, last_item, in_fetch, fetch_start;
  logic  fetch_req, desc_loaded;
  logic [ADDR_W-1:0] fetch_addr;
  desc_t fetched;

  assign sw_we       = cfg_we && !active;
  assign start_cmd   = sw_we && (cfg_sel == SEL_GO) && cfg_wdata[0];
  assign in_fetch    = (st == ST_FETCH);
  assign last_item   = (st == ST_WRITE) && mem_ack && (remain == CNT_W'(1));
  assign step_ev     = (st == ST_WRITE) && mem_ack && (remain != CNT_W'(1));
  assign fetch_start = (st == ST_END) && (next_ptr != '0);

  lldma_addr_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_sel(cfg_sel), .sw_data(cfg_wdata),
    .load(desc_loaded), .load_val(fetched), .step(step_ev),
    .src(src_addr), .dst(dst_addr), .nxt(next_ptr),
    .cnt(cnt), .bad_cfg(bad_cfg)
  );

  lldma_desc_fetch u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(fetch_start), .base(next_ptr),
    .mem_ack(mem_ack && in_fetch), .mem_rdata(mem_rdata),
    .req(fetch_req), .addr(fetch_addr),
    .loaded(desc_loaded), .desc(fetched)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      active <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      remain <= '0;
      data_q <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: if (start_cmd) begin
          st     <= ST_CHECK;
          active <= 1'b1;
        end
        ST_CHECK: begin
          if (bad_cfg) begin
            err    <= 1'b1;
            active <= 1'b0;
            st     <= ST_IDLE;
          end else if (cnt == '0) begin
            st <= ST_END;
          end else begin
            remain <= cnt;
            st     <= ST_READ;
          end
        end
        ST_READ: if (mem_ack) begin
          data_q <= mem_rdata;
          st     <= ST_WRITE;
        end
        ST_WRITE: begin
          if (last_item) st <= ST_END;
          else if (step_ev) begin
            remain <= remain - 1'b1;
            st     <= ST_READ;
          end
        end
        ST_END: begin
          if (next_ptr == '0) begin
            done   <= 1'b1;
            active <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            st <= ST_FETCH;
          end
        end
        ST_FETCH: if (desc_loaded) st <= ST_CHECK;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (st == ST_READ) || (st == ST_WRITE) || fetch_req;
    mem_we    = (st == ST_WRITE);
    mem_wdata = data_q;
    if (in_fetch)           mem_addr = fetch_addr;
    else if (st == ST_WRITE) mem_addr = dst_addr;
    else                    mem_addr = src_addr;
  end

endmodule

// File: rtl/lldma_channel_chk.sv
module lldma_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        done,
  input logic        err,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] src_addr,
  input logic [31:0] dst_addr,
  input logic [31:0] next_ptr,
  input logic        in_fetch,
  input logic        desc_loaded
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !active);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!active && !done));

  // R4
  next_align_chk: assert property (@(posedge clk) disable iff (!rst_n) next_ptr[1:0] == 2'b00);

  // R10
  atomic_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fetch && !desc_loaded) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(next_ptr)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  req_active_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> active);

endmodule

bind lldma_channel lldma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .done(done), .err(err),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .src_addr(src_addr), .dst_addr(dst_addr), .next_ptr(next_ptr),
  .in_fetch(in_fetch), .desc_loaded(desc_loaded)
);

// File: tb/sim_lldma_channel.sv
module sim_lldma_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        active, done, err;
  logic [31:0] src_addr, dst_addr, next_ptr;

  always #5 clk = ~clk;

  lldma_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .active(active), .done(done), .err(err),
    .src_addr(src_addr), .dst_addr(dst_addr), .next_ptr(next_ptr)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    int          didx;
  } txn_t;

  txn_t        expq[$];
  logic [31:0] mem [logic [31:0]];
  int checks = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0;
  int cycles = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] mk(input int cnt, input int wc, input bit si, input bit di);
    logic [31:0] c = '0;
    c[11:0]  = 12'(cnt);
    c[19:18] = 2'(wc);
    c[26]    = si;
    c[27]    = di;
    return c;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] c);
    mem[b] = s; mem[b+4] = d; mem[b+8] = n; mem[b+12] = c;
  endtask

  // behavioural reference: expected transactions and final register values
  task automatic model(input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] n0,
                       input logic [31:0] c0, output bit e_err,
                       output logic [31:0] fs, output logic [31:0] fd, output logic [31:0] fn);
    logic [31:0] s = s0, d = d0, n = n0 & ~32'd3, c = c0;
    logic [31:0] w [4];
    e_err = 0;
    for (int guard = 0; guard < 16; guard++) begin
      int wb;
      wb = (c[19:18] == 0) ? 1 : (c[19:18] == 1) ? 2 : 4;
      if (c[19:18] == 3 || (s % wb) != 0 || (d % wb) != 0) begin e_err = 1; break; end
      for (int i = 0; i < int'(c[11:0]); i++) begin
        if (i > 0) begin
          if (c[26]) s = s + wb;
          if (c[27]) d = d + wb;
        end
        expq.push_back('{1'b0, s, 32'h0, -1});
        expq.push_back('{1'b1, d, rd(s), -1});
      end
      if (n == 0) break;
      for (int k = 0; k < 4; k++) begin
        expq.push_back('{1'b0, n + 32'(4*k), 32'h0, k});
        w[k] = rd(n + 32'(4*k));
      end
      s = w[0]; d = w[1]; n = w[2] & ~32'd3; c = w[3];
    end
    fs = s; fd = d; fn = n;
  endtask

  // memory responder and per-clock comparison against the reference queue
  logic [7:0]  lfsr = 8'h5B;
  int          wait_n = 0;
  bit          armed = 0;
  logic [31:0] src_snap = '0;

  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst_n) begin
      if (done) done_cnt++;
      if (err)  err_cnt++;
      if (mem_req && !active) chk("R11", "request while inactive", 32'(mem_req), 32'd0);
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      armed = 0;
    end else if (rst_n && mem_req) begin
      if (!armed) begin wait_n = int'(lfsr % 3); armed = 1; end
      if (wait_n == 0) begin
        if (expq.size() == 0) begin
          chk("R2", "unexpected request addr", mem_addr, 32'hFFFF_FFFF);
        end else begin
          txn_t e;
          e = expq.pop_front();
          if (e.didx < 0) begin
            chk("R2", "direction", 32'(mem_we), 32'(e.we));
            chk("R3", "data address", mem_addr, e.addr);
            if (e.we) chk("R2", "write data", mem_wdata, e.data);
          end else begin
            chk("R5", "descriptor read dir", 32'(mem_we), 32'd0);
            chk("R5", "descriptor word addr", mem_addr, e.addr);
            if (e.didx == 0) src_snap = src_addr;
            else chk("R10", "src stable during fetch", src_addr, src_snap);
          end
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
        mem_ack = 1'b1;
        armed = 0;
      end else begin
        wait_n--;
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R7 watchdog: actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic prog(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input string name, input logic [31:0] s0, input logic [31:0] d0,
                          input logic [31:0] n0, input logic [31:0] c0, input bit poke);
    bit e_err;
    logic [31:0] fs, fd, fn;
    model(s0, d0, n0, c0, e_err, fs, fd, fn);
    prog(3'd0, s0); prog(3'd1, d0); prog(3'd2, n0); prog(3'd3, c0);
    chk("R1", {name, " src load"}, src_addr, s0);
    chk("R1", {name, " dst load"}, dst_addr, d0);
    done_cnt = 0; err_cnt = 0;
    prog(3'd4, 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R8", "still active at poke", 32'(active), 32'd1);
      prog(3'd2, 32'h0000_0700);
      prog(3'd0, 32'h0000_0900);
    end
    for (int t = 0; t < 3000 && active; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7", {name, " inactive"}, 32'(active), 32'd0);
    chk("R7", {name, " done pulses"}, 32'(done_cnt), e_err ? 32'd0 : 32'd1);
    chk("R6", {name, " err pulses"}, 32'(err_cnt), e_err ? 32'd1 : 32'd0);
    chk("R9", {name, " leftover expected txns"}, 32'(expq.size()), 32'd0);
    chk("R3", {name, " final src"}, src_addr, fs);
    chk("R3", {name, " final dst"}, dst_addr, fd);
    chk("R4", {name, " final next"}, next_ptr, fn);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset active", 32'(active), 32'd0);
    chk("R1", "reset done", 32'(done), 32'd0);
    chk("R1", "reset req", 32'(mem_req), 32'd0);
    chk("R1", "reset src", src_addr, 32'd0);
    chk("R1", "reset next", next_ptr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    prog(3'd2, 32'h0000_1237);
    chk("R4", "sw next low bits", next_ptr, 32'h0000_1234);
    prog(3'd5, 32'h0000_0001);
    chk("R1", "select 5 no start", 32'(active), 32'd0);

    run_case("w4 inc", 32'h1000, 32'h8000, 32'h0, mk(4, 2, 1, 1), 0);
    run_case("w2 src only", 32'h1100, 32'h8100, 32'h0, mk(3, 1, 1, 0), 0);
    run_case("w1 odd", 32'h1201, 32'h8203, 32'h0, mk(5, 0, 1, 1), 0);

    put_desc(32'h4000, 32'h1402, 32'h8402, 32'h4021, mk(3, 1, 1, 1));
    put_desc(32'h4020, 32'h1500, 32'h8500, 32'h4040, mk(0, 2, 1, 1));
    put_desc(32'h4040, 32'h1600, 32'h8600, 32'h0,    mk(2, 1, 0, 0));
    run_case("chain", 32'h1300, 32'h8300, 32'h4002, mk(6, 2, 1, 1), 1);

    run_case("zero count", 32'h1700, 32'h8700, 32'h0, mk(0, 2, 1, 1), 0);
    run_case("misaligned src", 32'h1802, 32'h8800, 32'h0, mk(2, 2, 1, 1), 0);
    run_case("reserved width", 32'h1900, 32'h8900, 32'h0, mk(2, 3, 1, 1), 0);

    put_desc(32'h4080, 32'h1B00, 32'h8B01, 32'h0, mk(2, 1, 1, 1));
    run_case("bad descriptor", 32'h1A00, 32'h8A00, 32'h4080, mk(1, 2, 1, 1), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule